// File: doc/BRIEF.md
# Code-Context Word-Usage Predictor

This block learns which words of a cache line a program really touches, so that the fetch issued on a miss can skip the words that will never be read. Its key is the code region of the instruction that missed: the miss PC with its low bits dropped. The data address plays no part. For each context the table keeps the used-word pattern last seen for a line that context brought in. On the next miss from the same context, that pattern is replayed as the fetch mask.

The predictor also tracks every resident line. For each one it keeps the context that filled it, the words actually fetched, and the words touched since the fill. Loads and stores arrive on an access port as a line slot and a word offset. An access to a word that was never fetched is a misprediction. It is reported so the cache can fetch that word as a miss of its own. When a line is evicted, its used mask becomes the new prediction for its context.

Top module: `word_use_predictor`

## Requirements
- R1: The context of a miss PC has two parts. The table index is PC bits [9:4] and selects one of 64 direct-mapped entries. The partial tag is PC bits [13:10]. When the indexed entry is valid and its tag matches, the predicted mask is the mask last stored in that entry.
- R2: When the indexed entry is invalid, or its tag differs, the predicted mask is all ones (the whole line is fetched).
- R3: Bit w of the returned mask stands for word w of the line. The bit of the word that caused the miss is always set in the returned mask.
- R4: `pred_valid` is high in exactly the cycle after a cycle with `miss_valid` high, and `pred_mask` is valid in that cycle.
- R5: A miss installs the line in slot `miss_line`. Its fetched mask is the returned mask, and its used mask holds only the missing word. Each later access to a resident line sets the accessed word's bit in its used mask.
- R6: Evicting a resident line stores its used mask and its filling context's tag into the table entry of that context, replacing the old contents. Evicting a slot that is not resident leaves the table unchanged.
- R7: An access to a resident line at a word outside its fetched mask raises `mis_valid` in the next cycle, with `mis_line` and `mis_word` naming the access. That word then counts as fetched, so a repeat access does not report again.
- R8: An access to a slot that is not resident is ignored. It raises no report and changes no state.
- R9: When an eviction writes the same table entry that a miss looks up in that cycle, the lookup returns the newly written mask and tag.
- R10: When one slot is named by more than one port in a cycle, a fill beats an eviction and an eviction beats an access. An access to a slot that is being filled or evicted in that cycle is ignored. An eviction together with a fill of the same slot saves the old line's used mask and then installs the new line.
- R11: After a synchronous active-high reset, every table entry and line slot is invalid and `pred_valid` and `mis_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Miss request strobe |
| miss_pc | input | 32 | PC of the instruction that missed |
| miss_word | input | 3 | Word offset that missed |
| miss_line | input | 3 | Line slot receiving the fill |
| acc_valid | input | 1 | Load/store access strobe |
| acc_line | input | 3 | Line slot accessed |
| acc_word | input | 3 | Word offset accessed |
| evict_valid | input | 1 | Eviction strobe |
| evict_line | input | 3 | Line slot evicted |
| pred_valid | output | 1 | Prediction response valid |
| pred_mask | output | 8 | Predicted fetch mask, bit w = word w |
| mis_valid | output | 1 | Misprediction report valid |
| mis_line | output | 3 | Line slot of the mispredicted access |
| mis_word | output | 3 | Word of the mispredicted access |

## Verification
A corrupted table entry stays hidden until a miss from its context comes along. It then shows in the returned mask one cycle after that miss. To expose it, the bench evicts a line and then misses again from the same context, both one cycle apart and back to back in the same cycle. A wrong fetched or used mask in a line slot shows one cycle after the next access to that slot, as a missing or spurious `mis_valid`. It also shows, after that slot's eviction, as a wrong mask on the following miss from its context. Same-cycle collisions on a single slot are driven directly, because a wrong priority leaves no trace until a later lookup.

// File: rtl/wup_pkg.sv
`timescale 1ns/1ps
package wup_pkg;
    parameter int WORDS   = 8;
    parameter int PC_W    = 32;
    parameter int IDX_LO  = 4;
    parameter int IDX_W   = 6;
    parameter int TAG_W   = 4;
    parameter int LINES   = 8;

    localparam int WOFF_W  = $clog2(WORDS);
    localparam int LINE_W  = $clog2(LINES);
    localparam int ENTRIES = 1 << IDX_W;

    typedef logic [WORDS-1:0] wmask_t;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [TAG_W-1:0] tag;
    } ctx_t;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        wmask_t           mask;
    } pent_t;

    typedef struct packed {
        logic   valid;
        ctx_t   ctx;
        wmask_t fetched;
        wmask_t used;
    } lstate_t;

    function automatic ctx_t ctx_of(input logic [PC_W-1:0] pc);
        ctx_t c;
        c.idx = pc[IDX_LO +: IDX_W];
        c.tag = pc[IDX_LO+IDX_W +: TAG_W];
        return c;
    endfunction

    function automatic wmask_t word_bit(input logic [WOFF_W-1:0] w);
        return wmask_t'(1) << w;
    endfunction
endpackage

// File: rtl/wup_table.sv
`timescale 1ns/1ps
module wup_table
    import wup_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  ctx_t   lk_ctx,
    output logic   lk_hit,
    output wmask_t lk_mask,
    input  logic   wr_en,
    input  ctx_t   wr_ctx,
    input  wmask_t wr_mask
);
    pent_t tbl [ENTRIES];
    pent_t sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
        end else if (wr_en) begin
            tbl[wr_ctx.idx] <= '{valid: 1'b1, tag: wr_ctx.tag, mask: wr_mask};
        end
    end

    // same-entry write is forwarded to the lookup (R9)
    always_comb begin
        if (wr_en && (wr_ctx.idx == lk_ctx.idx))
            sel = '{valid: 1'b1, tag: wr_ctx.tag, mask: wr_mask};
        else
            sel = tbl[lk_ctx.idx];
        lk_hit  = sel.valid && (sel.tag == lk_ctx.tag);
        lk_mask = sel.mask;
    end

    p_write_lands_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (tbl[$past(wr_ctx.idx)].valid &&
                   tbl[$past(wr_ctx.idx)].mask == $past(wr_mask) &&
                   tbl[$past(wr_ctx.idx)].tag  == $past(wr_ctx.tag)));
endmodule

// File: rtl/wup_lines.sv
`timescale 1ns/1ps
module wup_lines
    import wup_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_en,
    input  logic [LINE_W-1:0] fill_line,
    input  ctx_t              fill_ctx,
    input  wmask_t            fill_mask,
    input  logic [WOFF_W-1:0] fill_word,
    input  logic              ev_en,
    input  logic [LINE_W-1:0] ev_line,
    output logic              ev_hit,
    output ctx_t              ev_ctx,
    output wmask_t            ev_used,
    input  logic              acc_en,
    input  logic [LINE_W-1:0] acc_line,
    input  logic [WOFF_W-1:0] acc_word,
    output logic              mis_valid,
    output logic [LINE_W-1:0] mis_line,
    output logic [WOFF_W-1:0] mis_word
);
    lstate_t lines [LINES];
    lstate_t ev_st, acc_st;
    wmask_t  acc_bit;
    logic    acc_ok, acc_miss;

    always_comb begin
        ev_st   = lines[ev_line];
        ev_hit  = ev_en && ev_st.valid;
        ev_ctx  = ev_st.ctx;
        ev_used = ev_st.used;

        acc_st   = lines[acc_line];
        acc_bit  = word_bit(acc_word);
        // fill > evict > access on one slot (R10); dead slots ignored (R8)
        acc_ok   = acc_en && acc_st.valid &&
                   !(fill_en && fill_line == acc_line) &&
                   !(ev_en && ev_line == acc_line);
        acc_miss = acc_ok && ((acc_st.fetched & acc_bit) == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) lines[i] <= '0;
            mis_valid <= 1'b0;
            mis_line  <= '0;
            mis_word  <= '0;
        end else begin
            mis_valid <= acc_miss;
            mis_line  <= acc_line;
            mis_word  <= acc_word;
            if (acc_ok) begin
                lines[acc_line].used    <= acc_st.used | acc_bit;
                lines[acc_line].fetched <= acc_st.fetched | acc_bit;
            end
            if (ev_en) lines[ev_line].valid <= 1'b0;
            if (fill_en)
                lines[fill_line] <= '{valid: 1'b1, ctx: fill_ctx,
                                      fetched: fill_mask, used: word_bit(fill_word)};
        end
    end

    p_report_follows_access_r7: assert property (@(posedge clk) disable iff (rst)
        mis_valid |-> $past(acc_en));
    p_fill_resident_r5: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> (lines[$past(fill_line)].valid &&
                     lines[$past(fill_line)].fetched == $past(fill_mask)));
endmodule

// File: rtl/word_use_predictor.sv
`timescale 1ns/1ps
module word_use_predictor
    import wup_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    input  logic [PC_W-1:0]   miss_pc,
    input  logic [WOFF_W-1:0] miss_word,
    input  logic [LINE_W-1:0] miss_line,
    input  logic              acc_valid,
    input  logic [LINE_W-1:0] acc_line,
    input  logic [WOFF_W-1:0] acc_word,
    input  logic              evict_valid,
    input  logic [LINE_W-1:0] evict_line,
    output logic              pred_valid,
    output logic [WORDS-1:0]  pred_mask,
    output logic              mis_valid,
    output logic [LINE_W-1:0] mis_line,
    output logic [WOFF_W-1:0] mis_word
);
    ctx_t   lk_ctx, ev_ctx;
    logic   lk_hit, ev_hit;
    wmask_t lk_mask, ev_used, fill_mask;

    always_comb begin
        lk_ctx    = ctx_of(miss_pc);
        fill_mask = (lk_hit ? lk_mask : '1) | word_bit(miss_word);
    end

    wup_table u_table (
        .clk     (clk),
        .rst     (rst),
        .lk_ctx  (lk_ctx),
        .lk_hit  (lk_hit),
        .lk_mask (lk_mask),
        .wr_en   (ev_hit),
        .wr_ctx  (ev_ctx),
        .wr_mask (ev_used)
    );

    wup_lines u_lines (
        .clk       (clk),
        .rst       (rst),
        .fill_en   (miss_valid),
        .fill_line (miss_line),
        .fill_ctx  (lk_ctx),
        .fill_mask (fill_mask),
        .fill_word (miss_word),
        .ev_en     (evict_valid),
        .ev_line   (evict_line),
        .ev_hit    (ev_hit),
        .ev_ctx    (ev_ctx),
        .ev_used   (ev_used),
        .acc_en    (acc_valid),
        .acc_line  (acc_line),
        .acc_word  (acc_word),
        .mis_valid (mis_valid),
        .mis_line  (mis_line),
        .mis_word  (mis_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pred_valid <= 1'b0;
            pred_mask  <= '0;
        end else begin
            pred_valid <= miss_valid;
            pred_mask  <= fill_mask;
        end
    end

    p_answer_next_cycle_r4: assert property (@(posedge clk) disable iff (rst)
        miss_valid |=> pred_valid);
    p_no_spurious_answer_r4: assert property (@(posedge clk) disable iff (rst)
        !miss_valid |=> !pred_valid);
    p_miss_word_forced_r3: assert property (@(posedge clk) disable iff (rst)
        pred_valid |-> pred_mask[$past(miss_word)]);
endmodule

// File: tb/sim_word_use_predictor.sv
`timescale 1ns/1ps
module sim_word_use_predictor;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        miss_valid = 0, acc_valid = 0, evict_valid = 0;
    logic [31:0] miss_pc = '0;
    logic [2:0]  miss_word = '0, miss_line = '0, acc_line = '0, acc_word = '0, evict_line = '0;
    logic        pred_valid, mis_valid;
    logic [7:0]  pred_mask;
    logic [2:0]  mis_line, mis_word;

    always #2.5 clk = ~clk;

    word_use_predictor u0 (
        .clk(clk), .rst(rst),
        .miss_valid(miss_valid), .miss_pc(miss_pc), .miss_word(miss_word), .miss_line(miss_line),
        .acc_valid(acc_valid), .acc_line(acc_line), .acc_word(acc_word),
        .evict_valid(evict_valid), .evict_line(evict_line),
        .pred_valid(pred_valid), .pred_mask(pred_mask),
        .mis_valid(mis_valid), .mis_line(mis_line), .mis_word(mis_word)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    // reference model state
    bit       t_v [64];
    bit [3:0] t_t [64];
    bit [7:0] t_m [64];
    bit       l_v [8];
    bit [5:0] l_i [8];
    bit [3:0] l_t [8];
    bit [7:0] l_f [8];
    bit [7:0] l_u [8];

    bit       have_exp = 0;
    bit       e_pv, e_mv;
    bit [7:0] e_pm;
    bit [2:0] e_ml, e_mw;
    string    e_tag;

    function automatic bit [7:0] expected_mask(bit [31:0] pc, bit [2:0] w);
        bit [5:0] ix = pc[9:4];
        bit [3:0] tg = pc[13:10];
        bit [7:0] m  = (t_v[ix] && t_t[ix] == tg) ? t_m[ix] : 8'hFF;
        return m | (8'h01 << w);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s [%s]: actual %0h expected %0h", req, what, e_tag, act, exp);
        end
    endtask

    task automatic check_prev();
        if (!have_exp) return;
        chk(pred_valid == e_pv, "R4", "pred_valid", pred_valid, e_pv);
        if (e_pv) chk(pred_mask == e_pm, "R1/R2/R3", "pred_mask", pred_mask, e_pm);
        chk(mis_valid == e_mv, "R7/R8/R10", "mis_valid", mis_valid, e_mv);
        if (e_mv) chk({mis_line, mis_word} == {e_ml, e_mw}, "R7", "mis line/word",
                      {mis_line, mis_word}, {e_ml, e_mw});
    endtask

    task automatic step(bit mv, bit [31:0] pc, bit [2:0] mw, bit [2:0] ml,
                        bit av, bit [2:0] al, bit [2:0] aw,
                        bit ev, bit [2:0] el, string tag);
        bit [7:0] msk;
        bit       acc_ok;
        @(negedge clk);
        check_prev();
        miss_valid = mv; miss_pc = pc; miss_word = mw; miss_line = ml;
        acc_valid = av; acc_line = al; acc_word = aw;
        evict_valid = ev; evict_line = el;
        // eviction write first (bypassed into lookup, R9)
        if (ev && l_v[el]) begin
            t_v[l_i[el]] = 1; t_t[l_i[el]] = l_t[el]; t_m[l_i[el]] = l_u[el];
        end
        msk = expected_mask(pc, mw);
        e_pv = mv; e_pm = msk; e_mv = 0; e_ml = al; e_mw = aw; e_tag = tag;
        acc_ok = av && l_v[al] && !(mv && ml == al) && !(ev && el == al);
        if (acc_ok) begin
            l_u[al] |= 8'h01 << aw;
            if ((l_f[al] & (8'h01 << aw)) == 0) begin
                e_mv = 1;
                l_f[al] |= 8'h01 << aw;
            end
        end
        if (ev) l_v[el] = 0;
        if (mv) begin
            l_v[ml] = 1; l_i[ml] = pc[9:4]; l_t[ml] = pc[13:10];
            l_f[ml] = msk; l_u[ml] = 8'h01 << mw;
        end
        have_exp = 1;
    endtask

    function automatic bit [31:0] mkpc(int tg, int ix, int lo);
        return 32'((tg << 10) | (ix << 4) | lo);
    endfunction

    task automatic finish_run();
        if (done) return;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bit [31:0] pa;
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R11: outputs low after reset
        e_tag = "R11";
        chk(pred_valid == 0, "R11", "pred_valid", pred_valid, 0);
        chk(mis_valid == 0, "R11", "mis_valid", mis_valid, 0);

        pa = mkpc(0, 1, 3);
        step(1, pa, 2, 0, 0, 0, 0, 0, 0, "R2 cold");
        step(0, 0, 0, 0, 1, 0, 5, 0, 0, "R5 use");
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, "R6 evict");
        step(1, pa, 0, 1, 0, 0, 0, 0, 0, "R1 R3 replay");
        step(0, 0, 0, 0, 1, 1, 7, 0, 0, "R7 mispredict");
        step(0, 0, 0, 0, 1, 1, 7, 0, 0, "R7 repeat");
        step(0, 0, 0, 0, 1, 5, 2, 0, 0, "R8 dead slot");
        step(1, mkpc(1, 1, 0), 3, 2, 0, 0, 0, 0, 0, "R2 tag mismatch");
        step(1, pa, 1, 3, 0, 0, 0, 1, 1, "R9 bypass");
        step(0, 0, 0, 0, 1, 3, 6, 1, 3, "R10 access vs evict");
        step(1, pa, 1, 4, 0, 0, 0, 0, 0, "R10 access dropped");
        step(0, 0, 0, 0, 1, 4, 4, 0, 0, "R7 word4");
        step(1, pa, 0, 4, 1, 4, 5, 1, 4, "R10 fill vs evict");
        step(0, 0, 0, 0, 1, 4, 4, 0, 0, "R10 new line");
        step(0, 0, 0, 0, 1, 4, 2, 0, 0, "R7 new line");
        step(1, mkpc(0, 1, 0), 6, 5, 0, 0, 0, 1, 5, "R6 dead evict");

        for (int n = 0; n < 4000; n++) begin
            bit mv = ($urandom % 10) < 4;
            bit av = ($urandom % 10) < 6;
            bit ev = ($urandom % 10) < 2;
            step(mv, mkpc($urandom % 2, $urandom % 4, $urandom % 16),
                 3'($urandom), 3'($urandom), av, 3'($urandom), 3'($urandom),
                 ev, 3'($urandom), "random");
        end
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "drain");
        @(negedge clk);
        check_prev();
        finish_run();
    end
endmodule